// File: doc/BRIEF.md
# Level-2 Interrupt Aggregation Controller

This block gathers 32 interrupt request lines into a single active-high request toward a parent interrupt controller. Each source line is watched for a rising edge; an edge latches a per-source pending flag in a status register. A per-source mask decides which latched flags may reach the parent. The output request is high while at least one latched flag is unmasked.

Software reaches the block through a plain register bus: a byte address, a write strobe, write data and combinational read data. The status and the mask each have a readable view and two write-one-only registers, one that sets bits and one that clears them. Bits written as zero are left alone, so no read-modify-write is ever needed. Through the set register software can raise a source itself. Clearing a status bit acknowledges that source.

Top module: `l2_irq_agg`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFFFFFFFF (every source masked) and `parentIrq` is 0.
- R2: A 0-to-1 transition on `srcIrq[i]`, sampled on consecutive clock edges, sets status bit i at that edge. A source held high after its bit is cleared does not set the bit again.
- R3: A write to offset 0x04 sets every status bit whose write-data bit is 1.
- R4: A write to offset 0x08 clears every status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: When a clear write to 0x08 and a new rising edge hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x10 sets mask bits and a write to offset 0x14 clears mask bits, for each write-data bit that is 1. Offset 0x0C reads the mask, where 1 means masked.
- R7: `parentIrq` is a register that goes high one clock after the vector status AND NOT mask becomes nonzero and goes low one clock after that vector becomes zero.
- R8: Offset 0x00 reads the status register. Reads of any other offset except 0x0C, including the four write-only offsets and unaligned or unused addresses, return zero.
- R9: Writes to offsets 0x00 and 0x0C change neither status nor mask.
- R10: Writing 0xFFFFFFFF to 0x10 and then 0xFFFFFFFF to 0x08 leaves every source masked, every status bit clear and `parentIrq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIrq | input | 32 | Interrupt request lines, one per source |
| busAddr | input | 5 | Register byte address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| parentIrq | output | 1 | Aggregated request to the parent controller |

## Verification
The bench attacks the cycle where a clear write and a fresh edge meet on the same bit: a design that gives the clear priority drops the event and reads back zero. It holds a source high across a clear to catch a design that latches on level rather than edge, which would re-raise the bit at once. It times `parentIrq` to the exact cycle after mask and status changes, so a combinational output or an extra stage is caught, and it writes to the read-only offsets and reads the write-only ones, which a loose address decoder would turn into mask or status corruption or nonzero read data.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;
  localparam int NUM_SRC = 32;
  localparam int ADDR_W  = 5;

  // Byte offsets; the address decode depends on these exact values.
  localparam int OFS_STAT_VIEW = 'h00;
  localparam int OFS_STAT_SET  = 'h04;
  localparam int OFS_STAT_CLR  = 'h08;
  localparam int OFS_MASK_VIEW = 'h0C;
  localparam int OFS_MASK_SET  = 'h10;
  localparam int OFS_MASK_CLR  = 'h14;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   statSet;
    logic   statClr;
    logic   maskSet;
    logic   maskClr;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/l2_irq_ctrl.sv
module l2_irq_ctrl
  import l2_irq_pkg::*;
#(
  parameter int ADDR_W = l2_irq_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (busAddr == ADDR_W'(OFS_STAT_VIEW)) strb.rdSel = RD_STAT;
    if (busAddr == ADDR_W'(OFS_MASK_VIEW)) strb.rdSel = RD_MASK;
    if (busWr) begin
      strb.statSet = (busAddr == ADDR_W'(OFS_STAT_SET));
      strb.statClr = (busAddr == ADDR_W'(OFS_STAT_CLR));
      strb.maskSet = (busAddr == ADDR_W'(OFS_MASK_SET));
      strb.maskClr = (busAddr == ADDR_W'(OFS_MASK_CLR));
    end
  end
endmodule

// File: rtl/l2_irq_datapath.sv
module l2_irq_datapath
  import l2_irq_pkg::*;
#(
  parameter int NUM_SRC = l2_irq_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [NUM_SRC-1:0] busWdata,
  input  regStrobe_t         strb,
  output logic [NUM_SRC-1:0] busRdata,
  output logic [NUM_SRC-1:0] srcPrevQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               parentIrq
);
  logic [NUM_SRC-1:0] pendVec;

  // Per-source edge detector and pending flag; an edge outranks a clear.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic riseHit;
    logic setHit;
    logic clrHit;
    assign riseHit = srcIrq[g] & ~srcPrevQ[g];
    assign setHit  = strb.statSet & busWdata[g];
    assign clrHit  = strb.statClr & busWdata[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcPrevQ[g] <= 1'b0;
        statusQ[g]  <= 1'b0;
      end else begin
        srcPrevQ[g] <= srcIrq[g];
        statusQ[g]  <= riseHit | setHit | (statusQ[g] & ~clrHit);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strb.maskSet) begin
      maskQ <= maskQ | busWdata;
    end else if (strb.maskClr) begin
      maskQ <= maskQ & ~busWdata;
    end
  end

  assign pendVec = statusQ & ~maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parentIrq <= 1'b0;
    else       parentIrq <= |pendVec;
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STAT: busRdata = statusQ;
      RD_MASK: busRdata = maskQ;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/l2_irq_agg.sv
module l2_irq_agg
  import l2_irq_pkg::*;
#(
  parameter int NUM_SRC = l2_irq_pkg::NUM_SRC,
  parameter int ADDR_W  = l2_irq_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               parentIrq
);
  regStrobe_t         strb;
  logic [NUM_SRC-1:0] srcPrevQ;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  l2_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strb    (strb)
  );

  l2_irq_datapath #(.NUM_SRC(NUM_SRC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIrq    (srcIrq),
    .busWdata  (busWdata),
    .strb      (strb),
    .busRdata  (busRdata),
    .srcPrevQ  (srcPrevQ),
    .statusQ   (statusQ),
    .maskQ     (maskQ),
    .parentIrq (parentIrq)
  );
endmodule

// File: rtl/l2_irq_agg_chk.sv
module l2_irq_agg_chk
  import l2_irq_pkg::*;
#(
  parameter int NUM_SRC = l2_irq_pkg::NUM_SRC,
  parameter int ADDR_W  = l2_irq_pkg::ADDR_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIrq,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [NUM_SRC-1:0] busWdata,
  input logic [NUM_SRC-1:0] srcPrevQ,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               parentIrq
);
  // R2 and R5: an edge always leaves its status bit set, clear or not
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcIrq & ~srcPrevQ)) |=>
      ((statusQ & $past(srcIrq & ~srcPrevQ)) == $past(srcIrq & ~srcPrevQ)));

  // R3: set register raises the written bits
  a_r3_soft_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_STAT_SET)) |=>
      ((statusQ & $past(busWdata)) == $past(busWdata)));

  // R6: mask set and mask clear
  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_MASK_SET)) |=>
      ((maskQ & $past(busWdata)) == $past(busWdata)));
  a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_MASK_CLR)) |=>
      ((maskQ & $past(busWdata)) == '0));

  // R7: output follows the pending vector one clock later
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & ~maskQ)) |=> parentIrq);
  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & ~maskQ)) |=> !parentIrq);

  // R9: writes to the read views leave the mask untouched
  a_r9_ro_mask: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_W'(OFS_STAT_VIEW) ||
               busAddr == ADDR_W'(OFS_MASK_VIEW))) |=> $stable(maskQ));
endmodule

bind l2_irq_agg l2_irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .srcIrq    (srcIrq),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .srcPrevQ  (srcPrevQ),
  .statusQ   (statusQ),
  .maskQ     (maskQ),
  .parentIrq (parentIrq)
);

// File: tb/sim_l2_irq_agg.sv
`timescale 1ns/1ps
module sim_l2_irq_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIrq = '0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        parentIrq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  l2_irq_agg u0 (
    .clk       (clk),
    .rstN      (rstN),
    .srcIrq    (srcIrq),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .parentIrq (parentIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive one write cycle; returns at the negedge after the register update.
  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic regRead(logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic expectReg(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic tReset;
    expectReg("R1 status", 5'h00, 32'h0);
    expectReg("R1 mask", 5'h0C, 32'hFFFF_FFFF);
    check("R1 parentIrq", {31'b0, parentIrq}, 32'h0);
  endtask

  task automatic tEdge;
    srcIrq = 32'h4;
    @(negedge clk);
    expectReg("R2 edge latch", 5'h00, 32'h4);
    @(negedge clk);
    check("R7 masked source quiet", {31'b0, parentIrq}, 32'h0);
    regWrite(5'h08, 32'h4);
    @(negedge clk);
    expectReg("R2 held level no relatch", 5'h00, 32'h0);
    srcIrq = '0;
    @(negedge clk);
  endtask

  task automatic tSoftAndMask;
    regWrite(5'h04, 32'h100);
    expectReg("R3 soft set", 5'h00, 32'h100);
    regWrite(5'h14, 32'h100);
    check("R7 output one cycle late", {31'b0, parentIrq}, 32'h0);
    expectReg("R6 mask clear", 5'h0C, 32'hFFFF_FEFF);
    @(negedge clk);
    check("R7 output raised", {31'b0, parentIrq}, 32'h1);
    regWrite(5'h10, 32'h100);
    expectReg("R6 mask set", 5'h0C, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 output drops on mask", {31'b0, parentIrq}, 32'h0);
    regWrite(5'h14, 32'h100);
    @(negedge clk);
  endtask

  task automatic tClear;
    regWrite(5'h08, 32'h0);
    expectReg("R4 zero bits keep", 5'h00, 32'h100);
    regWrite(5'h08, 32'h100);
    expectReg("R4 clear", 5'h00, 32'h0);
    check("R7 still high one cycle", {31'b0, parentIrq}, 32'h1);
    @(negedge clk);
    check("R7 low after clear", {31'b0, parentIrq}, 32'h0);
  endtask

  task automatic tPriority;
    regWrite(5'h04, 32'h18);
    srcIrq = 32'h8;
    regWrite(5'h08, 32'h18);
    expectReg("R5 edge beats clear", 5'h00, 32'h8);
    regWrite(5'h08, 32'h8);
    expectReg("R5 later clear works", 5'h00, 32'h0);
    srcIrq = '0;
    @(negedge clk);
  endtask

  task automatic tAccess;
    regWrite(5'h00, 32'hFFFF_FFFF);
    regWrite(5'h0C, 32'h0);
    expectReg("R9 status untouched", 5'h00, 32'h0);
    expectReg("R9 mask untouched", 5'h0C, 32'hFFFF_FEFF);
    regWrite(5'h04, 32'h1);
    expectReg("R8 set reg reads zero", 5'h04, 32'h0);
    expectReg("R8 clr reg reads zero", 5'h08, 32'h0);
    expectReg("R8 mask set reads zero", 5'h10, 32'h0);
    expectReg("R8 mask clr reads zero", 5'h14, 32'h0);
    expectReg("R8 unused reads zero", 5'h1C, 32'h0);
    expectReg("R8 unaligned reads zero", 5'h01, 32'h0);
    regWrite(5'h08, 32'h1);
  endtask

  task automatic tFlush;
    regWrite(5'h04, 32'hA5A5_A5A5);
    regWrite(5'h14, 32'hFFFF_0000);
    @(negedge clk);
    check("R10 pre-flush request", {31'b0, parentIrq}, 32'h1);
    regWrite(5'h10, 32'hFFFF_FFFF);
    regWrite(5'h08, 32'hFFFF_FFFF);
    expectReg("R10 status flushed", 5'h00, 32'h0);
    expectReg("R10 all masked", 5'h0C, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 request low", {31'b0, parentIrq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEdge();
    tSoftAndMask();
    tClear();
    tPriority();
    tAccess();
    tFlush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule